// File: doc/BRIEF.md
# Dual-Channel Transmit Watchdog

This block times and gates transmissions for a terminal that is attached to two redundant serial buses. It keeps a one-hot channel selection. An accepted command sets the selection to the channel that carried the command. A controller-side choice can also set it. A transmit request on an enabled channel first produces a short active-low start pulse, which triggers an external watchdog. Transmit enable for the selected channel then goes high.

When transmit enable rises, an internal window timer starts and drives a monitor output for a fixed number of cycles. If the transmitter is still on when the window runs out, transmit enable is forced off. It stays off until the next command arrives. A new command also clears a running window, so the next transmission gets a full window again. Each channel has an active-low inhibit input. While it is low, transmission on that channel is blocked.

The line coding and the transceivers sit outside this block. Default timing assumes a 16 MHz clock: a 12,800-cycle window (800 µs) and a 4-cycle start pulse (250 ns).

Top module: `txwd_dual`

## Requirements
- R1: After reset, both select outputs are low, the start pulse output is high (inactive), the monitor output is low and both transmit enables are low.
- R2: A command with `cmd_valid_i` high sets `sel_o` to one-hot of `cmd_chan_i` from the next cycle (channel 0 is bit 0, channel 1 is bit 1). At most one select bit is ever high.
- R3: A controller choice with `ctl_sel_valid_i` high sets `sel_o` to one-hot of `ctl_sel_chan_i` from the next cycle. When a command and a controller choice arrive in the same cycle, the command's channel wins.
- R4: A transmit request made while idle, with a channel selected and that channel's inhibit high, drives `start_pulse_n_o` low for exactly PULSE_CYC cycles, starting the cycle after the request. No transmit enable is high during the pulse.
- R5: The cycle after the pulse ends, the selected channel's transmit enable and `wd_mon_o` go high. `wd_mon_o` stays high for exactly WINDOW_CYC cycles, even if the transmission ends earlier.
- R6: `tx_done_i` high during a transmission drops transmit enable from the next cycle.
- R7: If the window runs out while the transmitter is still on, transmit enable is forced low. Further transmit requests produce no pulse until a command arrives.
- R8: A command clears the monitor output and ends any pulse or transmission from the next cycle. The next transmission gets a full WINDOW_CYC window.
- R9: A low inhibit on the selected channel makes a transmit request be dropped with no start pulse. During a transmission, a low inhibit holds that channel's transmit enable low in the same cycle. The other channel's inhibit has no effect.
- R10: A transmit request while no channel is selected is dropped with no start pulse.
- R11: A command that arrives in the same cycle as window expiry returns the block to idle, not to the locked state, so the next request starts a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid_i | input | 1 | A command was accepted this cycle |
| cmd_chan_i | input | 1 | Channel that carried the command |
| ctl_sel_valid_i | input | 1 | Controller selects a channel this cycle |
| ctl_sel_chan_i | input | 1 | Channel chosen by the controller |
| tx_req_i | input | 1 | Request to start a transmission on the selected channel |
| tx_done_i | input | 1 | Current transmission has finished |
| tx_inh_n_i | input | 2 | Per-channel inhibit, low blocks the channel |
| sel_o | output | 2 | One-hot channel select |
| start_pulse_n_o | output | 1 | Active-low start pulse for an external watchdog |
| wd_mon_o | output | 1 | High while the transmit window runs |
| tx_en_o | output | 2 | Per-channel transmit enable |

## Verification
Window expiry and the arrival of a new command can land on the same clock edge. The bench counts monitor-high cycles up to the last cycle of the window and raises a command exactly then. It then judges by issuing a transmit request: a start pulse must appear, which proves the block went idle and not into the lockout. A transmit request that meets a low inhibit, and a transmit request that meets an empty selection, are each judged by the absence of any start pulse over the following cycles.

// File: rtl/txwd_pkg.sv
package txwd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_TX    = 2'd2,
    ST_LOCK  = 2'd3
  } txwd_state_e;

endpackage

// File: rtl/txwd_chan_sel.sv
module txwd_chan_sel #(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CH_W-1:0]   cmd_chan,
  input  logic              ctl_valid,
  input  logic [CH_W-1:0]   ctl_chan,
  output logic [NUM_CH-1:0] sel
);

  logic [NUM_CH-1:0] sel_q;
  logic [NUM_CH-1:0] sel_d;
  logic              sel_en;

  // next-state: the command has priority over the controller choice
  always_comb begin
    sel_d  = sel_q;
    sel_en = 1'b0;
    if (ctl_valid && (int'(ctl_chan) < NUM_CH)) begin
      sel_en = 1'b1;
      for (int i = 0; i < NUM_CH; i++) sel_d[i] = (int'(ctl_chan) == i);
    end
    if (cmd_valid && (int'(cmd_chan) < NUM_CH)) begin
      sel_en = 1'b1;
      for (int i = 0; i < NUM_CH; i++) sel_d[i] = (int'(cmd_chan) == i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  assign sel = sel_q;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_q)); // R2
  AST_CMD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> sel_q[$past(cmd_chan)]); // R3

endmodule

// File: rtl/txwd_window.sv
module txwd_window #(
  parameter int WINDOW_CYC = 12800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clear,
  output logic active,
  output logic expire
);

  localparam int CW = $clog2(WINDOW_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(WINDOW_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    cnt_en = 1'b0;
    if (clear) begin
      run_d  = 1'b0;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (load) begin
      run_d  = 1'b1;
      cnt_d  = LOAD_VAL;
      cnt_en = 1'b1;
    end else if (run_q) begin
      cnt_en = 1'b1;
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign active = run_q;
  assign expire = run_q && (cnt_q == '0);

  AST_WIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !active); // R8
  AST_WIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> (active && !expire)); // R5

endmodule

// File: rtl/txwd_seq.sv
module txwd_seq
  import txwd_pkg::*;
#(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic tx_req,
  input  logic tx_done,
  input  logic chan_ok,
  input  logic win_expire,
  output logic pulse_n,
  output logic tx_act,
  output logic win_load,
  output logic win_clear
);

  localparam int PW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_CYC - 1);

  txwd_state_e   st_q, st_d;
  logic [PW-1:0] pc_q, pc_d;
  logic          load_d;

  always_comb begin
    st_d   = st_q;
    pc_d   = pc_q;
    load_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (tx_req && chan_ok) begin
          st_d = ST_PULSE;
          pc_d = PULSE_LAST;
        end
      end
      ST_PULSE: begin
        if (pc_q == '0) begin
          st_d   = ST_TX;
          load_d = 1'b1;
        end else begin
          pc_d = pc_q - 1'b1;
        end
      end
      ST_TX: begin
        if (tx_done)         st_d = ST_IDLE;
        else if (win_expire) st_d = ST_LOCK;
      end
      ST_LOCK: st_d = ST_LOCK;
      default: st_d = ST_IDLE;
    endcase
    if (cmd_valid) begin
      st_d   = ST_IDLE;
      load_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      pc_q <= '0;
    end else begin
      st_q <= st_d;
      pc_q <= pc_d;
    end
  end

  assign pulse_n   = (st_q != ST_PULSE);
  assign tx_act    = (st_q == ST_TX);
  assign win_load  = load_d;
  assign win_clear = cmd_valid;

  AST_DROP_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && tx_req && !chan_ok && !cmd_valid) |=> pulse_n); // R9
  AST_EXPIRE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TX && win_expire && !tx_done && !cmd_valid) |=> (st_q == ST_LOCK)); // R7
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK && !cmd_valid) |=> !tx_act && pulse_n); // R7
  AST_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (st_q == ST_IDLE)); // R8
  AST_DONE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TX && tx_done) |=> !tx_act); // R6

endmodule

// File: rtl/txwd_dual.sv
module txwd_dual #(
  parameter int NUM_CH     = 2,
  parameter int WINDOW_CYC = 12800,
  parameter int PULSE_CYC  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid_i,
  input  logic                cmd_chan_i,
  input  logic                ctl_sel_valid_i,
  input  logic                ctl_sel_chan_i,
  input  logic                tx_req_i,
  input  logic                tx_done_i,
  input  logic [NUM_CH-1:0]   tx_inh_n_i,
  output logic [NUM_CH-1:0]   sel_o,
  output logic                start_pulse_n_o,
  output logic                wd_mon_o,
  output logic [NUM_CH-1:0]   tx_en_o
);

  localparam int CH_W = 1;

  logic [NUM_CH-1:0] sel;
  logic              chan_ok;
  logic              win_load, win_clear, win_active, win_expire;
  logic              tx_act, pulse_n;

  txwd_chan_sel #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid_i),
    .cmd_chan  (cmd_chan_i),
    .ctl_valid (ctl_sel_valid_i),
    .ctl_chan  (ctl_sel_chan_i),
    .sel       (sel)
  );

  assign chan_ok = |(sel & tx_inh_n_i);

  txwd_seq #(.PULSE_CYC(PULSE_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid_i),
    .tx_req     (tx_req_i),
    .tx_done    (tx_done_i),
    .chan_ok    (chan_ok),
    .win_expire (win_expire),
    .pulse_n    (pulse_n),
    .tx_act     (tx_act),
    .win_load   (win_load),
    .win_clear  (win_clear)
  );

  txwd_window #(.WINDOW_CYC(WINDOW_CYC)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (win_load),
    .clear  (win_clear),
    .active (win_active),
    .expire (win_expire)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_txen
    assign tx_en_o[g] = tx_act && sel[g] && tx_inh_n_i[g];
  end

  assign sel_o           = sel;
  assign start_pulse_n_o = pulse_n;
  assign wd_mon_o        = win_active;

  AST_NO_TXEN_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !start_pulse_n_o |-> (tx_en_o == '0)); // R4
  AST_PULSE_THEN_MON: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(start_pulse_n_o) && !$past(cmd_valid_i)) |-> wd_mon_o); // R5
  AST_TXEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_en_o)); // R2

endmodule

// File: tb/txwd_dual_tb.sv
module txwd_dual_tb;

  localparam int WIN = 64;
  localparam int PUL = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid_i, cmd_chan_i, ctl_sel_valid_i, ctl_sel_chan_i;
  logic       tx_req_i, tx_done_i;
  logic [1:0] tx_inh_n_i;
  logic [1:0] sel_o, tx_en_o;
  logic       start_pulse_n_o, wd_mon_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  txwd_dual #(.NUM_CH(2), .WINDOW_CYC(WIN), .PULSE_CYC(PUL)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid_i), .cmd_chan_i(cmd_chan_i),
    .ctl_sel_valid_i(ctl_sel_valid_i), .ctl_sel_chan_i(ctl_sel_chan_i),
    .tx_req_i(tx_req_i), .tx_done_i(tx_done_i), .tx_inh_n_i(tx_inh_n_i),
    .sel_o(sel_o), .start_pulse_n_o(start_pulse_n_o),
    .wd_mon_o(wd_mon_o), .tx_en_o(tx_en_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic send_cmd(input logic ch);
    cmd_valid_i = 1'b1; cmd_chan_i = ch; cyc(); cmd_valid_i = 1'b0;
  endtask

  // request and count low pulse cycles; returns with first post-pulse cycle
  task automatic req_pulse(output int n);
    tx_req_i = 1'b1; cyc(); tx_req_i = 1'b0;
    n = 0;
    while (!start_pulse_n_o && n < 50) begin n++; cyc(); end
  endtask

  // request and count pulse-low cycles over a fixed span
  task automatic req_nopulse(output int lows);
    tx_req_i = 1'b1; cyc(); tx_req_i = 1'b0;
    lows = 0;
    for (int i = 0; i < 8; i++) begin
      if (!start_pulse_n_o || tx_en_o != 2'b00) lows++;
      cyc();
    end
  endtask

  // counts remaining monitor-high cycles, including the current one
  task automatic count_mon(inout int n);
    while (wd_mon_o && n < WIN + 20) begin n++; cyc(); end
  endtask

  task automatic t_reset();
    chk(sel_o == 2'b00, "R1 sel", sel_o, 0);
    chk(start_pulse_n_o == 1'b1, "R1 pulse", start_pulse_n_o, 1);
    chk(wd_mon_o == 1'b0, "R1 mon", wd_mon_o, 0);
    chk(tx_en_o == 2'b00, "R1 txen", tx_en_o, 0);
  endtask

  task automatic t_no_sel();
    int l;
    req_nopulse(l);
    chk(l == 0, "R10 no selection drop", l, 0);
  endtask

  task automatic t_select();
    send_cmd(1'b1);
    chk(sel_o == 2'b10, "R2 cmd ch1", sel_o, 2);
    send_cmd(1'b0);
    chk(sel_o == 2'b01, "R2 cmd ch0", sel_o, 1);
    ctl_sel_valid_i = 1'b1; ctl_sel_chan_i = 1'b1; cyc(); ctl_sel_valid_i = 1'b0;
    chk(sel_o == 2'b10, "R3 ctl ch1", sel_o, 2);
    cmd_valid_i = 1'b1; cmd_chan_i = 1'b0;
    ctl_sel_valid_i = 1'b1; ctl_sel_chan_i = 1'b1;
    cyc();
    cmd_valid_i = 1'b0; ctl_sel_valid_i = 1'b0;
    chk(sel_o == 2'b01, "R3 cmd wins", sel_o, 1);
  endtask

  task automatic t_normal();
    int n, m;
    send_cmd(1'b0);
    req_pulse(n);
    chk(n == PUL, "R4 pulse length", n, PUL);
    chk(tx_en_o == 2'b01, "R5 txen ch0", tx_en_o, 1);
    chk(wd_mon_o == 1'b1, "R5 mon high", wd_mon_o, 1);
    m = 0;
    for (int i = 0; i < 10; i++) begin m++; cyc(); end
    tx_done_i = 1'b1; m++; cyc(); tx_done_i = 1'b0;
    chk(tx_en_o == 2'b00, "R6 done drops txen", tx_en_o, 0);
    chk(wd_mon_o == 1'b1, "R5 mon persists", wd_mon_o, 1);
    count_mon(m);
    chk(m == WIN, "R5 window length", m, WIN);
  endtask

  task automatic t_expire();
    int n, m, l;
    send_cmd(1'b1);
    req_pulse(n);
    chk(tx_en_o == 2'b10, "R5 txen ch1", tx_en_o, 2);
    m = 0;
    count_mon(m);
    chk(m == WIN, "R7 window before lock", m, WIN);
    chk(tx_en_o == 2'b00, "R7 txen forced off", tx_en_o, 0);
    req_nopulse(l);
    chk(l == 0, "R7 locked ignores request", l, 0);
    send_cmd(1'b1);
    req_pulse(n);
    chk(n == PUL, "R7 command unlocks", n, PUL);
    tx_done_i = 1'b1; cyc(); tx_done_i = 1'b0;
    m = 0; count_mon(m);
  endtask

  task automatic t_restart();
    int n, m;
    send_cmd(1'b0);
    req_pulse(n);
    for (int i = 0; i < 20; i++) cyc();
    send_cmd(1'b0);
    chk(wd_mon_o == 1'b0, "R8 command clears mon", wd_mon_o, 0);
    chk(tx_en_o == 2'b00, "R8 command ends tx", tx_en_o, 0);
    req_pulse(n);
    chk(n == PUL, "R8 pulse after restart", n, PUL);
    m = 0;
    tx_done_i = 1'b1; m++; cyc(); tx_done_i = 1'b0;
    count_mon(m);
    chk(m == WIN, "R8 full window after restart", m, WIN);
  endtask

  task automatic t_inhibit();
    int n, l, m;
    send_cmd(1'b0);
    tx_inh_n_i = 2'b10;
    req_nopulse(l);
    chk(l == 0, "R9 inhibited request dropped", l, 0);
    tx_inh_n_i = 2'b01;
    req_pulse(n);
    chk(n == PUL, "R9 other inhibit no effect", n, PUL);
    chk(tx_en_o == 2'b01, "R9 txen with other inhibited", tx_en_o, 1);
    tx_inh_n_i = 2'b00; #1;
    chk(tx_en_o == 2'b00, "R9 inhibit gates txen", tx_en_o, 0);
    tx_inh_n_i = 2'b11; #1;
    chk(tx_en_o == 2'b01, "R9 txen back", tx_en_o, 1);
    tx_done_i = 1'b1; cyc(); tx_done_i = 1'b0;
    m = 0; count_mon(m);
  endtask

  task automatic t_collide();
    int n, m;
    send_cmd(1'b1);
    req_pulse(n);
    m = 1;
    while (m < WIN) begin m++; cyc(); end
    chk(wd_mon_o == 1'b1, "R11 last window cycle", wd_mon_o, 1);
    send_cmd(1'b1);
    chk(wd_mon_o == 1'b0, "R11 mon low", wd_mon_o, 0);
    req_pulse(n);
    chk(n == PUL, "R11 not locked", n, PUL);
    tx_done_i = 1'b1; cyc(); tx_done_i = 1'b0;
    m = 0; count_mon(m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid_i = 1'b0; cmd_chan_i = 1'b0;
    ctl_sel_valid_i = 1'b0; ctl_sel_chan_i = 1'b0;
    tx_req_i = 1'b0; tx_done_i = 1'b0; tx_inh_n_i = 2'b11;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_no_sel();
    t_select();
    t_normal();
    t_expire();
    t_restart();
    t_inhibit();
    t_collide();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule